// File: doc/BRIEF.md
# Predicated floating-point flag comparator

This unit produces the next value of a four-bit condition flag set (negative, zero, carry, overflow) for a conditional compare of two floating-point operands. Each request carries both operands, a format selector for half, single or double precision, a condition code and a four-bit fallback value. The condition code is tested against the flags the unit currently holds. When the test passes, the operands go through a quiet IEEE 754 comparison and the outcome is encoded into new flags. When the test fails, the fallback value becomes the new flag set and no comparison takes place.

Each request is accepted on a clock edge that has `valid_i` high. The flag register is the only state. Two indications come back in the same cycle as the request: one for an invalid operation, raised when the comparison sees a signaling NaN, and one for the reserved format code, which leaves the flags untouched. Register access, trap handling, rounding control and denormal flushing belong to the surrounding pipeline.

Top module: `fcc_top`

## Requirements
- R1: The format field selects the operand width: 2'b00 is single precision using bits [31:0], 2'b01 is double precision using bits [63:0], and 2'b11 is half precision using bits [15:0]. Operand bits above the selected width have no effect.
- R2: Format 2'b10 is reserved. With `valid_i` high it drives `undef_o` high in the same cycle, keeps `invalid_o` low and leaves `flags_o` unchanged after the edge.
- R3: When the condition is false against the current flags, the flags after the edge equal `alt_flags_i`, with bit 3 as N, bit 2 as Z, bit 1 as C and bit 0 as V, and `invalid_o` stays low even for signaling NaN operands.
- R4: Condition codes 0 to 13 test, in order: Z set, Z clear, C set, C clear, N set, N clear, V set, V clear, (C and not Z), its inverse, N equal to V, N not equal to V, (not Z and N equal to V), its inverse.
- R5: When the condition passes and either operand is a NaN, the new flags are 4'b0011 (unordered).
- R6: When the condition passes with ordered operands, the new flags are 4'b1000 when the first operand is less, 4'b0110 when equal and 4'b0010 when greater.
- R7: Positive and negative zero compare equal, infinities order by sign against each other and against finite values, and subnormal values compare by value with no flushing.
- R8: `invalid_o` is high in the request cycle exactly when `valid_i` is high, the format is legal, the condition passes and at least one operand is a signaling NaN (exponent all ones, non-zero fraction with its top bit clear); a quiet NaN alone leaves it low.
- R9: `flags_o` changes only on an edge with `valid_i` high and a legal format; reset clears it to 4'b0000, and `invalid_o` and `undef_o` are low when `valid_i` is low.
- R10: Condition codes 14 and 15 always pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request qualifier; the flag register updates on an edge with this high |
| fmt_i | input | 2 | Operand format selector |
| cond_i | input | 4 | Condition code tested against the current flags |
| alt_flags_i | input | 4 | Fallback flag value used when the condition fails |
| opa_i | input | 64 | First operand, right-aligned |
| opb_i | input | 64 | Second operand, right-aligned |
| flags_o | output | 4 | Current flags {N,Z,C,V} |
| invalid_o | output | 1 | Invalid operation indication for the current request |
| undef_o | output | 1 | Reserved format indication for the current request |

## Verification
The bench walks every condition code across all sixteen flag states, so a design with a swapped pair of codes or with code 15 inverted like the other odd codes would load the fallback where a compare was due. It compares signed zeros, infinities, negative pairs and adjacent subnormals, where a design comparing raw bit patterns or flushing subnormals would report the wrong ordering. It sends quiet and signaling NaNs with passing and failing conditions, catching a design that flags quiet NaNs or raises invalid without comparing, and it puts garbage in the unused upper operand bits and sends the reserved format, catching a design that reads the wrong slice or updates the flags on an undefined request.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [1:0] {
    FMT_SGL = 2'b00,
    FMT_DBL = 2'b01,
    FMT_RSV = 2'b10,
    FMT_HLF = 2'b11
  } fmt_e;

  localparam int HLF_EXP = 5;
  localparam int HLF_MAN = 10;
  localparam int SGL_EXP = 8;
  localparam int SGL_MAN = 23;
  localparam int DBL_EXP = 11;
  localparam int DBL_MAN = 52;
  localparam int OPND_W  = 1 + DBL_EXP + DBL_MAN;
  localparam int MAG_W   = OPND_W - 1;
  localparam int NUM_FMT = 3;

  localparam logic [3:0] FLG_LT = 4'b1000;
  localparam logic [3:0] FLG_EQ = 4'b0110;
  localparam logic [3:0] FLG_GT = 4'b0010;
  localparam logic [3:0] FLG_UN = 4'b0011;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } fclass_t;

  function automatic int fmt_exp(input int idx);
    return (idx == 0) ? HLF_EXP : (idx == 1) ? SGL_EXP : DBL_EXP;
  endfunction

  function automatic int fmt_man(input int idx);
    return (idx == 0) ? HLF_MAN : (idx == 1) ? SGL_MAN : DBL_MAN;
  endfunction

endpackage

// File: rtl/fcc_unpack.sv
module fcc_unpack
  import fcc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] raw_i,
  output fclass_t      cls_o
);

  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;
  logic             exp_max;

  always_comb begin
    expo    = raw_i[W-2:MAN_W];
    frac    = raw_i[MAN_W-1:0];
    exp_max = &expo;
    cls_o.sign = raw_i[W-1];
    cls_o.nan  = exp_max && (|frac);
    cls_o.snan = exp_max && (|frac) && !frac[MAN_W-1];
    cls_o.zero = (expo == '0) && (frac == '0);
    cls_o.mag  = MAG_W'({expo, frac});
  end

endmodule

// File: rtl/fcc_operand.sv
module fcc_operand
  import fcc_pkg::*;
(
  input  fmt_e              fmt_i,
  input  logic [OPND_W-1:0] raw_i,
  output fclass_t           cls_o
);

  fclass_t cls_fmt [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = fmt_exp(g);
    localparam int MW = fmt_man(g);
    localparam int FW = 1 + EW + MW;
    fcc_unpack #(.EXP_W(EW), .MAN_W(MW)) u_unpack (
      .raw_i (raw_i[FW-1:0]),
      .cls_o (cls_fmt[g])
    );
  end

  always_comb begin
    unique case (fmt_i)
      FMT_HLF: cls_o = cls_fmt[0];
      FMT_DBL: cls_o = cls_fmt[2];
      default: cls_o = cls_fmt[1];
    endcase
  end

endmodule

// File: rtl/fcc_compare.sv
module fcc_compare
  import fcc_pkg::*;
(
  input  fclass_t    a_i,
  input  fclass_t    b_i,
  output logic [3:0] res_o,
  output logic       sig_nan_o
);

  logic mag_lt;

  always_comb begin
    mag_lt    = a_i.mag < b_i.mag;
    sig_nan_o = a_i.snan || b_i.snan;
    if (a_i.nan || b_i.nan)          res_o = FLG_UN;
    else if (a_i.zero && b_i.zero)   res_o = FLG_EQ;
    else if (a_i.sign != b_i.sign)   res_o = a_i.sign ? FLG_LT : FLG_GT;
    else if (a_i.mag == b_i.mag)     res_o = FLG_EQ;
    else if (mag_lt ^ a_i.sign)      res_o = FLG_LT;
    else                             res_o = FLG_GT;
  end

endmodule

// File: rtl/fcc_cond_eval.sv
module fcc_cond_eval (
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       pass_o
);

  logic n, z, c, v, base, invert;

  always_comb begin
    {n, z, c, v} = flags_i;
    unique case (cond_i[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c && !z;
      3'd5: base = (n == v);
      3'd6: base = !z && (n == v);
      default: base = 1'b1;
    endcase
    invert = cond_i[0] && (cond_i != 4'hF);
    pass_o = base ^ invert;
  end

endmodule

// File: rtl/fcc_top.sv
module fcc_top
  import fcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [1:0]  fmt_i,
  input  logic [3:0]  cond_i,
  input  logic [3:0]  alt_flags_i,
  input  logic [63:0] opa_i,
  input  logic [63:0] opb_i,
  output logic [3:0]  flags_o,
  output logic        invalid_o,
  output logic        undef_o
);

  fmt_e       fmt;
  fclass_t    a_cls, b_cls;
  logic [3:0] cmp_res, flags_q, flags_d;
  logic       cmp_sig, cond_pass, legal, upd_en;

  assign fmt   = fmt_e'(fmt_i);
  assign legal = (fmt != FMT_RSV);

  fcc_operand u_opa (.fmt_i(fmt), .raw_i(opa_i), .cls_o(a_cls));
  fcc_operand u_opb (.fmt_i(fmt), .raw_i(opb_i), .cls_o(b_cls));

  fcc_compare u_cmp (
    .a_i       (a_cls),
    .b_i       (b_cls),
    .res_o     (cmp_res),
    .sig_nan_o (cmp_sig)
  );

  fcc_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (cond_pass)
  );

  always_comb begin
    upd_en  = valid_i && legal;
    flags_d = cond_pass ? cmp_res : alt_flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= 4'b0000;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags_o   = flags_q;
  assign invalid_o = valid_i && legal && cond_pass && cmp_sig;
  assign undef_o   = valid_i && !legal;

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic [1:0] fmt_i,
  input logic [3:0] cond_i,
  input logic [3:0] alt_flags_i,
  input logic [3:0] flags_o,
  input logic       invalid_o,
  input logic       undef_o
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(flags_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !invalid_o && !undef_o); // R9

  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && fmt_i == 2'b10 |=> $stable(flags_o)); // R2

  AST_RSV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && fmt_i == 2'b10 |-> undef_o && !invalid_o); // R2

  AST_INV_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |=> flags_o == 4'b0011); // R5

  AST_EQ_FAIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && fmt_i != 2'b10 && cond_i == 4'h0 && !flags_o[2]
      |=> flags_o == $past(alt_flags_i)); // R3

  AST_NV_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && fmt_i != 2'b10 && cond_i == 4'hF
      |=> flags_o inside {4'b1000, 4'b0110, 4'b0010, 4'b0011}); // R10

endmodule

bind fcc_top fcc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_i     (valid_i),
  .fmt_i       (fmt_i),
  .cond_i      (cond_i),
  .alt_flags_i (alt_flags_i),
  .flags_o     (flags_o),
  .invalid_o   (invalid_o),
  .undef_o     (undef_o)
);

// File: tb/fcc_top_tb.sv
`timescale 1ns/1ps
module fcc_top_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [1:0]  fmt_i;
  logic [3:0]  cond_i, alt_flags_i;
  logic [63:0] opa_i, opb_i;
  logic [3:0]  flags_o;
  logic        invalid_o, undef_o;
  int          checks = 0;
  int          fails = 0;

  localparam logic [1:0] SG = 2'b00, DB = 2'b01, RS = 2'b10, HF = 2'b11;
  localparam logic [3:0] C_AL = 4'hE, C_NV = 4'hF, C_MI = 4'h4, C_EQ = 4'h0;
  localparam logic [63:0] S_ONE = 64'h3F80_0000, S_TWO = 64'h4000_0000;
  localparam logic [63:0] S_QNAN = 64'h7FC0_0000, S_SNAN = 64'h7F80_0001;

  always #2.5 clk = ~clk;

  fcc_top u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] f, input logic [3:0] c, input logic [3:0] alt,
                       input logic [63:0] a, input logic [63:0] b, input logic [3:0] ef,
                       input logic ei, input logic eu, input string tag);
    @(negedge clk);
    valid_i = 1'b1; fmt_i = f; cond_i = c; alt_flags_i = alt; opa_i = a; opb_i = b;
    #1;
    chk(invalid_o === ei, {tag, " invalid"}, {3'b0, invalid_o}, {3'b0, ei});
    chk(undef_o === eu, {tag, " undef"}, {3'b0, undef_o}, {3'b0, eu});
    @(negedge clk);
    valid_i = 1'b0;
    chk(flags_o === ef, {tag, " flags"}, flags_o, ef);
  endtask

  // unordered compare, then MI fails (N=0) and loads v
  task automatic set_flags(input logic [3:0] v);
    do_op(SG, C_AL, 4'h0, S_QNAN, S_ONE, 4'b0011, 1'b0, 1'b0, "R5 setup");
    do_op(SG, C_MI, v, S_ONE, S_TWO, v, 1'b0, 1'b0, "R3 setup");
  endtask

  function automatic bit exp_pass(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      4'd0: return z;            4'd1: return !z;
      4'd2: return cy;           4'd3: return !cy;
      4'd4: return n;            4'd5: return !n;
      4'd6: return v;            4'd7: return !v;
      4'd8: return cy && !z;     4'd9: return !(cy && !z);
      4'd10: return n == v;      4'd11: return n != v;
      4'd12: return !z && n == v; 4'd13: return !(!z && n == v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic t_reset;
    chk(flags_o === 4'b0000, "R9 reset flags", flags_o, 4'b0000);
    chk(invalid_o === 1'b0 && undef_o === 1'b0, "R9 reset indications",
        {2'b0, invalid_o, undef_o}, 4'b0000);
  endtask

  task automatic t_formats;
    do_op(SG, C_AL, 0, S_ONE, S_TWO, 4'b1000, 0, 0, "R1 single less");
    do_op(DB, C_AL, 0, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 4'b0010, 0, 0, "R1 double greater");
    do_op(HF, C_AL, 0, 64'hFFFF_FFFF_FFFF_3C00, 64'h1234_5678_0000_4000, 4'b1000, 0, 0, "R1 half upper ignored");
    do_op(SG, C_AL, 0, 64'hDEAD_BEEF_3F80_0000, S_ONE, 4'b0110, 0, 0, "R1 single upper ignored");
    do_op(HF, C_AL, 0, 64'h0000_0000_0000_C000, 64'h3C00, 4'b1000, 0, 0, "R6 half negative less");
  endtask

  task automatic t_reserved;
    set_flags(4'b1010);
    do_op(RS, C_AL, 4'h5, S_SNAN, S_ONE, 4'b1010, 0, 1, "R2 reserved format");
  endtask

  task automatic t_conditions;
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [3:0] ef;
        ef = exp_pass(4'(c), 4'(f)) ? 4'b1000 : 4'b0101;
        set_flags(4'(f));
        do_op(SG, 4'(c), 4'b0101, S_ONE, S_TWO, ef, 0, 0,
              (c >= 14) ? "R10 always-pass code" : "R4 condition code");
      end
    end
  endtask

  task automatic t_nans;
    do_op(SG, C_AL, 0, S_QNAN, S_ONE, 4'b0011, 0, 0, "R5 quiet NaN no invalid R8");
    do_op(SG, C_NV, 0, S_ONE, S_SNAN, 4'b0011, 1, 0, "R8 signaling NaN invalid");
    do_op(DB, C_AL, 0, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0000, 4'b0011, 1, 0, "R8 double sNaN");
    do_op(HF, C_AL, 0, 64'h7E00, 64'h7C01, 4'b0011, 1, 0, "R8 half sNaN");
    set_flags(4'b0000);
    do_op(SG, C_EQ, 4'b1101, S_SNAN, S_SNAN, 4'b1101, 0, 0, "R3 fail suppresses invalid");
  endtask

  task automatic t_values;
    do_op(SG, C_AL, 0, 64'h8000_0000, 64'h0, 4'b0110, 0, 0, "R7 signed zeros equal");
    do_op(SG, C_AL, 0, 64'hFF80_0000, 64'h7F80_0000, 4'b1000, 0, 0, "R7 -inf < +inf");
    do_op(SG, C_AL, 0, 64'h7F80_0000, 64'h7F7F_FFFF, 4'b0010, 0, 0, "R7 +inf > max");
    do_op(SG, C_AL, 0, 64'h1, 64'h2, 4'b1000, 0, 0, "R7 subnormal order");
    do_op(SG, C_AL, 0, 64'h8000_0001, 64'h0, 4'b1000, 0, 0, "R7 neg subnormal < zero");
    do_op(SG, C_AL, 0, 64'hC000_0000, 64'hBF80_0000, 4'b1000, 0, 0, "R6 -2 < -1");
    do_op(SG, C_AL, 0, 64'hBF80_0000, 64'hC000_0000, 4'b0010, 0, 0, "R6 -1 > -2");
  endtask

  task automatic t_hold;
    set_flags(4'b1001);
    @(negedge clk);
    fmt_i = SG; cond_i = C_AL; opa_i = S_ONE; opb_i = S_TWO; alt_flags_i = 4'h3;
    repeat (3) @(negedge clk);
    chk(flags_o === 4'b1001, "R9 hold without valid", flags_o, 4'b1001);
    chk(invalid_o === 1'b0 && undef_o === 1'b0, "R9 idle indications",
        {2'b0, invalid_o, undef_o}, 4'b0000);
  endtask

  task automatic run_all;
    valid_i = 0; fmt_i = 0; cond_i = 0; alt_flags_i = 0; opa_i = 0; opb_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_reserved();
    t_conditions();
    t_nans();
    t_values();
    t_hold();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule